// File: doc/BRIEF.md
# Multichannel ADC Sequencer Register Block

This block is the register front end of a twelve-channel 12-bit converter. Software reaches it over a simple 32-bit read/write bus with byte offsets. Channel enables and interrupt masks are each handled as a group of three registers: a write-ones-to-set port, a write-ones-to-clear port and a read-only view of the stored value.

A start command captures the enabled set and converts each of those channels once, lowest index first. For each channel it raises a request to the analog core and holds it until the core answers with a done pulse and a 12-bit sample. The sample goes into that channel's own result slot and into a shared last-result register, and it raises the channel's end-of-conversion flag.

Reading a channel's result clears its flag. A registered interrupt line is high while any flag that is also unmasked is set.

Top module: `mcadc_ctrl`

## Requirements
- R1: After reset the channel enables, the interrupt mask, the end-of-conversion flags and the last-result register read 0, and `irq` and `conv_req` are low.
- R2: A write to offset 0x10 ORs the data bits [11:0] into the channel enables. A write to 0x14 clears the enable bits where the data has ones. Offset 0x18 reads the enables in bits [11:0] with zero above. Data bits above 11 are ignored.
- R3: Offsets 0x24 and 0x28 set and clear bits of the interrupt mask in the same way, and 0x2C reads the mask. Writing all ones to 0x28 masks every channel.
- R4: `irq` is high exactly when the AND of the flags and the mask was nonzero at the previous clock edge.
- R5: Writing bit 1 of offset 0x00 starts a pass over the channels enabled at that moment, in ascending index order, each converted once. Only one request is outstanding at a time. `conv_req` stays high with a stable `conv_chan` until `conv_done`.
- R6: The sample for channel n is read at offset 0x50 + 4*n in bits [11:0], with zero above. Offset 0x20 returns the most recently converted sample.
- R7: Offset 0x30 reads the end-of-conversion flags, bit n for channel n. A flag is set when its sample is stored and cleared by a read of that channel's result offset. A read of 0x20 clears no flag.
- R8: A start while a pass is running is ignored. A start with no channel enabled converts nothing.
- R9: Writing bit 0 of offset 0x00 returns every register to its reset value, drops `conv_req` and abandons the running pass. It takes priority over a start bit written at the same time.
- R10: Offset 0xFC reads the VERSION parameter. Offsets 0x00, 0x04 and 0x1C, and every other undefined offset, read 0, and writes to undefined offsets change nothing.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| conv_req | output | 1 | Conversion request to the analog core |
| conv_chan | output | 4 | Channel being requested |
| conv_done | input | 1 | Core completion pulse |
| conv_data | input | 12 | Sample returned with `conv_done` |
| irq | output | 1 | Level interrupt |

## Verification
The bench runs single-channel, sparse and full enable masks and compares the order of the requests the core receives with the ascending order of the enabled set. A sequencer that skipped, repeated or reordered channels would fail that comparison.

A second start is issued in the middle of a pass, and the enables are cleared at the same point. A design that restarted the pass, or read the enables live, would show a different request count.

The bench also checks that a result read clears only its own flag while a read of the last-result register clears none. A flag that cleared on the wrong read would leave `irq` high, or drop it, at the wrong time. Software reset is applied while a request is outstanding, and a pass that kept running afterwards would show up as further requests.

// File: rtl/mcadc_pkg.sv
`timescale 1ns/1ps
package mcadc_pkg;
  localparam int BUS_AW = 8;

  localparam logic [7:0] OFS_CTRL     = 8'h00;
  localparam logic [7:0] OFS_CH_SET   = 8'h10;
  localparam logic [7:0] OFS_CH_CLR   = 8'h14;
  localparam logic [7:0] OFS_CH_STAT  = 8'h18;
  localparam logic [7:0] OFS_LAST     = 8'h20;
  localparam logic [7:0] OFS_IE_SET   = 8'h24;
  localparam logic [7:0] OFS_IE_CLR   = 8'h28;
  localparam logic [7:0] OFS_IE_MASK  = 8'h2C;
  localparam logic [7:0] OFS_EOC      = 8'h30;
  localparam logic [7:0] OFS_RES_BASE = 8'h50;
  localparam logic [7:0] OFS_VERSION  = 8'hFC;

  localparam int CTRL_SWR_BIT   = 0;
  localparam int CTRL_START_BIT = 1;

  // index of the lowest set bit, 0 when none is set
  function automatic logic [4:0] lowest_set(input logic [31:0] v);
    logic [4:0] idx;
    idx = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) idx = 5'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/mcadc_regs.sv
`timescale 1ns/1ps
module mcadc_regs
  import mcadc_pkg::*;
#(
  parameter int NUM_CH  = 12,
  parameter int RES_W   = 12,
  parameter int DATA_W  = 32,
  parameter logic [DATA_W-1:0] VERSION = 32'h0001_0200
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [NUM_CH-1:0]    eoc_flags,
  input  logic [RES_W-1:0]     last_res,
  output logic [NUM_CH-1:0]    chan_en,
  output logic [NUM_CH-1:0]    irq_mask,
  output logic                 start_pulse,
  output logic                 swr_pulse,
  output logic [NUM_CH-1:0]    rd_clr,
  output logic                 res_rd_en,
  output logic [$clog2(NUM_CH)-1:0] res_rd_idx,
  output logic                 rsel_res_q,
  output logic [DATA_W-1:0]    reg_rdata_q
);
  localparam int IDX_W = $clog2(NUM_CH);
  localparam logic [8:0] RES_END = 9'(OFS_RES_BASE) + 9'(4 * NUM_CH);

  logic             srst;
  logic             ctrl_wr;
  logic             res_hit;
  logic [7:0]       res_off;
  logic [DATA_W-1:0] rd_mux;
  logic             unused_bits;

  assign ctrl_wr     = bus_wr_en && (bus_addr == OFS_CTRL);
  assign swr_pulse   = ctrl_wr && bus_wdata[CTRL_SWR_BIT];
  assign start_pulse = ctrl_wr && bus_wdata[CTRL_START_BIT] && !bus_wdata[CTRL_SWR_BIT];
  assign srst        = rst || swr_pulse;

  assign res_off    = bus_addr - OFS_RES_BASE;
  assign res_hit    = (bus_addr >= OFS_RES_BASE) && ({1'b0, bus_addr} < RES_END) &&
                      (bus_addr[1:0] == 2'b00);
  assign res_rd_idx = res_off[IDX_W+1:2];
  assign res_rd_en  = bus_rd_en && res_hit;
  assign rd_clr     = res_rd_en ? (NUM_CH'(1) << res_rd_idx) : '0;

  assign unused_bits = ^{bus_wdata[DATA_W-1:NUM_CH], res_off[7:IDX_W+2], res_off[1:0]};

  always_comb begin
    case (bus_addr)
      OFS_CH_STAT: rd_mux = DATA_W'(chan_en);
      OFS_IE_MASK: rd_mux = DATA_W'(irq_mask);
      OFS_EOC:     rd_mux = DATA_W'(eoc_flags);
      OFS_LAST:    rd_mux = DATA_W'(last_res);
      OFS_VERSION: rd_mux = VERSION;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      chan_en     <= '0;
      irq_mask    <= '0;
      rsel_res_q  <= 1'b0;
      reg_rdata_q <= '0;
    end else begin
      if (bus_wr_en) begin
        case (bus_addr)
          OFS_CH_SET: chan_en  <= chan_en  |  bus_wdata[NUM_CH-1:0];
          OFS_CH_CLR: chan_en  <= chan_en  & ~bus_wdata[NUM_CH-1:0];
          OFS_IE_SET: irq_mask <= irq_mask |  bus_wdata[NUM_CH-1:0];
          OFS_IE_CLR: irq_mask <= irq_mask & ~bus_wdata[NUM_CH-1:0];
          default: ;
        endcase
      end
      if (bus_rd_en) begin
        rsel_res_q  <= res_hit;
        reg_rdata_q <= rd_mux;
      end
    end
  end
endmodule

// File: rtl/mcadc_seq.sv
`timescale 1ns/1ps
module mcadc_seq
  import mcadc_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int RES_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [NUM_CH-1:0]         chan_en,
  input  logic                      conv_done,
  input  logic [RES_W-1:0]          conv_data,
  output logic                      conv_req,
  output logic [$clog2(NUM_CH)-1:0] conv_chan,
  output logic                      res_wr_en,
  output logic [$clog2(NUM_CH)-1:0] res_wr_idx,
  output logic [RES_W-1:0]          res_wr_data
);
  localparam int IDX_W = $clog2(NUM_CH);

  logic              busy_q;
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] pend_left;
  logic [4:0]        nxt;
  logic              unused_nxt;

  assign nxt        = lowest_set(32'(pend_q));
  assign unused_nxt = ^nxt;
  assign pend_left  = pend_q & ~(NUM_CH'(1) << conv_chan);

  assign res_wr_en   = conv_req && conv_done;
  assign res_wr_idx  = conv_chan;
  assign res_wr_data = conv_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      pend_q    <= '0;
      conv_req  <= 1'b0;
      conv_chan <= '0;
    end else if (!busy_q) begin
      if (start && (|chan_en)) begin
        pend_q <= chan_en;
        busy_q <= 1'b1;
      end
    end else if (!conv_req) begin
      conv_chan <= nxt[IDX_W-1:0];
      conv_req  <= 1'b1;
    end else if (conv_done) begin
      conv_req <= 1'b0;
      pend_q   <= pend_left;
      if (pend_left == '0) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mcadc_store.sv
`timescale 1ns/1ps
module mcadc_store #(
  parameter int NUM_CH = 12,
  parameter int RES_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [$clog2(NUM_CH)-1:0] wr_idx,
  input  logic [RES_W-1:0]          wr_data,
  input  logic                      rd_en,
  input  logic [$clog2(NUM_CH)-1:0] rd_idx,
  input  logic [NUM_CH-1:0]         rd_clr,
  output logic [RES_W-1:0]          rd_res,
  output logic [NUM_CH-1:0]         eoc_q,
  output logic [RES_W-1:0]          last_q
);
  localparam int IDX_W = $clog2(NUM_CH);
  localparam int DEPTH = 1 << IDX_W;

  logic [RES_W-1:0]  mem [DEPTH];
  logic [RES_W-1:0]  rd_raw_q;
  logic [NUM_CH-1:0] valid_q;
  logic              rd_valid_q;
  logic [NUM_CH-1:0] set_vec;

  assign set_vec = wr_en ? (NUM_CH'(1) << wr_idx) : '0;
  assign rd_res  = rd_valid_q ? rd_raw_q : '0;

  // plain one-write one-read array, no reset: maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_raw_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= '0;
      rd_valid_q <= 1'b0;
      eoc_q      <= '0;
      last_q     <= '0;
    end else begin
      valid_q <= valid_q | set_vec;
      eoc_q   <= (eoc_q & ~rd_clr) | set_vec;
      if (wr_en) last_q <= wr_data;
      if (rd_en) rd_valid_q <= valid_q[rd_idx];
    end
  end
endmodule

// File: rtl/mcadc_ctrl.sv
`timescale 1ns/1ps
module mcadc_ctrl
  import mcadc_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int RES_W  = 12,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] VERSION = 32'h0001_0200
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr_en,
  input  logic                      bus_rd_en,
  input  logic [BUS_AW-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      conv_req,
  output logic [$clog2(NUM_CH)-1:0] conv_chan,
  input  logic                      conv_done,
  input  logic [RES_W-1:0]          conv_data,
  output logic                      irq
);
  localparam int IDX_W = $clog2(NUM_CH);

  logic              swr_pulse, start_pulse, srst;
  logic [NUM_CH-1:0] chan_en, irq_mask, rd_clr, eoc_flags;
  logic              res_rd_en, rsel_res_q;
  logic [IDX_W-1:0]  res_rd_idx, res_wr_idx;
  logic [DATA_W-1:0] reg_rdata_q;
  logic [RES_W-1:0]  last_res, rd_res, res_wr_data;
  logic              res_wr_en;

  assign srst = rst || swr_pulse;

  mcadc_regs #(
    .NUM_CH(NUM_CH), .RES_W(RES_W), .DATA_W(DATA_W), .VERSION(VERSION)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .eoc_flags(eoc_flags), .last_res(last_res),
    .chan_en(chan_en), .irq_mask(irq_mask),
    .start_pulse(start_pulse), .swr_pulse(swr_pulse),
    .rd_clr(rd_clr), .res_rd_en(res_rd_en), .res_rd_idx(res_rd_idx),
    .rsel_res_q(rsel_res_q), .reg_rdata_q(reg_rdata_q)
  );

  mcadc_seq #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_seq (
    .clk(clk), .rst(srst), .start(start_pulse), .chan_en(chan_en),
    .conv_done(conv_done), .conv_data(conv_data),
    .conv_req(conv_req), .conv_chan(conv_chan),
    .res_wr_en(res_wr_en), .res_wr_idx(res_wr_idx), .res_wr_data(res_wr_data)
  );

  mcadc_store #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_store (
    .clk(clk), .rst(srst),
    .wr_en(res_wr_en), .wr_idx(res_wr_idx), .wr_data(res_wr_data),
    .rd_en(res_rd_en), .rd_idx(res_rd_idx), .rd_clr(rd_clr),
    .rd_res(rd_res), .eoc_q(eoc_flags), .last_q(last_res)
  );

  assign bus_rdata = rsel_res_q ? DATA_W'(rd_res) : reg_rdata_q;

  always_ff @(posedge clk) begin
    if (srst) irq <= 1'b0;
    else      irq <= |(eoc_flags & irq_mask);
  end
endmodule

// File: rtl/mcadc_chk.sv
`timescale 1ns/1ps
module mcadc_chk
  import mcadc_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] VERSION = 32'h0001_0200
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_wr_en,
  input logic                      bus_rd_en,
  input logic [BUS_AW-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic                      conv_req,
  input logic [$clog2(NUM_CH)-1:0] conv_chan,
  input logic                      conv_done,
  input logic                      irq,
  input logic [NUM_CH-1:0]         eoc_flags,
  input logic [NUM_CH-1:0]         irq_mask
);
  logic swr;
  assign swr = bus_wr_en && (bus_addr == OFS_CTRL) && bus_wdata[CTRL_SWR_BIT];

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_done && !swr) |=> conv_req);
  // R5
  chan_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_done && !swr) |=> $stable(conv_chan));
  // R5
  chan_range_chk: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> (int'(conv_chan) < NUM_CH));
  // R7
  eoc_set_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_req && conv_done && !swr) |=> eoc_flags[$past(conv_chan)]);
  // R4
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((eoc_flags & irq_mask) == '0) |=> !irq);
  // R4
  irq_high_chk: assert property (@(posedge clk) disable iff (rst)
    (((eoc_flags & irq_mask) != '0) && !swr) |=> irq);
  // R10
  version_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && (bus_addr == OFS_VERSION) && !swr) |=> (bus_rdata == VERSION));
  // R9
  swr_chk: assert property (@(posedge clk) disable iff (rst)
    swr |=> (!conv_req && (eoc_flags == '0) && (irq_mask == '0)));
endmodule

bind mcadc_ctrl mcadc_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
  .irq(irq), .eoc_flags(eoc_flags), .irq_mask(irq_mask)
);

// File: tb/test_mcadc_ctrl.sv
`timescale 1ns/1ps
module test_mcadc_ctrl;
  localparam int NCH = 12;
  localparam int LAT = 3;
  localparam logic [31:0] VER = 32'h0001_0200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        conv_req;
  logic [3:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  int log_n = 0, conv_cnt = 0, lat_cnt = 0;
  int order_log [64];
  logic [11:0] exp_res [NCH];

  always #2.5 clk = ~clk;

  mcadc_ctrl #(.NUM_CH(NCH), .RES_W(12), .DATA_W(32), .VERSION(VER)) i_mcadc_ctrl (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .irq(irq)
  );

  // analog core stand-in: answers each request after LAT cycles
  always @(posedge clk) begin
    if (rst) begin
      conv_done <= 1'b0;
      lat_cnt   <= 0;
    end else if (conv_done) begin
      conv_done <= 1'b0;
    end else if (conv_req) begin
      if (lat_cnt == LAT) begin
        logic [11:0] d;
        d = 12'((int'(conv_chan) * 12'h111 + conv_cnt * 12'h03B) & 12'hFFF);
        conv_done <= 1'b1;
        conv_data <= d;
        exp_res[conv_chan] <= d;
        if (log_n < 64) order_log[log_n] <= int'(conv_chan);
        log_n    <= log_n + 1;
        conv_cnt <= conv_cnt + 1;
        lat_cnt  <= 0;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      lat_cnt <= 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_convs(input int target);
    for (int g = 0; g < 3000 && log_n < target; g++) @(negedge clk);
    idle(4);
  endtask

  function automatic int popc(input logic [11:0] m);
    int c = 0;
    for (int i = 0; i < NCH; i++) c += int'(m[i]);
    return c;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [11:0] en_m, ie_m;
    logic [11:0] masks [16];
    idle(5);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 conv_req", 32'(conv_req), 0);
    rd(8'h18, r); check("R1 chan status", r, 0);
    rd(8'h2C, r); check("R1 mask", r, 0);
    rd(8'h30, r); check("R1 eoc", r, 0);
    rd(8'h20, r); check("R1 last", r, 0);

    // R10 version and undefined offsets; R11 read latency
    rd(8'hFC, r); check("R10 R11 version", r, VER);
    rd(8'h04, r); check("R10 offset 04", r, 0);
    rd(8'h1C, r); check("R10 offset 1C", r, 0);
    rd(8'h00, r); check("R10 control reads zero", r, 0);

    // R2 enable set/clear sweep
    en_m = '0;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] s, c;
      s = 32'(i) * 32'h9E37_79B1;
      c = (32'(i) * 32'h7F4A_7C15) >> 7;
      wr(8'h10, s); en_m |= s[11:0];
      rd(8'h18, r); check("R2 after set", r, 32'(en_m));
      wr(8'h14, c); en_m &= ~c[11:0];
      rd(8'h18, r); check("R2 after clear", r, 32'(en_m));
    end
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, r); check("R2 status read-only", r, 32'(en_m));

    // R3 mask set/clear
    ie_m = '0;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] s, c;
      s = 32'h0000_0A5F << i;
      c = 32'h0000_0333 << (7 - i);
      wr(8'h24, s); ie_m |= s[11:0];
      wr(8'h28, c); ie_m &= ~c[11:0];
      rd(8'h2C, r); check("R3 mask", r, 32'(ie_m));
    end

    // R10 writes to undefined offsets change nothing
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h18, r); check("R10 enables untouched", r, 32'(en_m));
    rd(8'h2C, r); check("R10 mask untouched", r, 32'(ie_m));
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h2C, r); check("R3 all-ones disable", r, 0);

    // conversion sweep
    for (int i = 0; i < NCH; i++) masks[i] = 12'(1 << i);
    masks[12] = 12'hFFF; masks[13] = 12'hA5A; masks[14] = 12'h0F1; masks[15] = 12'h801;
    wr(8'h24, 32'hFFF);
    for (int k = 0; k < 16; k++) begin
      logic [11:0] m;
      int pos, hi;
      m = masks[k];
      wr(8'h14, 32'hFFF);
      wr(8'h10, 32'(m));
      log_n = 0;
      wr(8'h00, 32'h2);
      wait_convs(popc(m));
      check("R5 conversion count", 32'(log_n), 32'(popc(m)));
      pos = 0; hi = 0;
      for (int c = 0; c < NCH; c++) begin
        if (m[c]) begin
          check("R5 ascending order", 32'(order_log[pos]), 32'(c));
          pos++; hi = c;
        end
      end
      check("R4 irq with flags", 32'(irq), 1);
      rd(8'h20, r); check("R6 last result", r, 32'(exp_res[hi]));
      rd(8'h30, r); check("R7 flags after pass, last read clears none", r, 32'(m));
      for (int c = 0; c < NCH; c++) begin
        if (m[c]) begin
          rd(8'h50 + 8'(4 * c), r); check("R6 channel result", r, 32'(exp_res[c]));
        end
      end
      rd(8'h30, r); check("R7 flags cleared by result reads", r, 0);
      idle(2);
      check("R4 irq low", 32'(irq), 0);
    end

    // R8 start with nothing enabled
    wr(8'h14, 32'hFFF);
    log_n = 0;
    wr(8'h00, 32'h2);
    idle(50);
    check("R8 empty start", 32'(log_n), 0);
    check("R8 empty start req", 32'(conv_req), 0);

    // R8 start during a pass is ignored; R5 enables snapshot at start
    wr(8'h10, 32'hFFF);
    log_n = 0;
    wr(8'h00, 32'h2);
    idle(10);
    wr(8'h00, 32'h2);
    wr(8'h14, 32'hFFF);
    wait_convs(12);
    idle(100);
    check("R8 restart ignored", 32'(log_n), 12);
    rd(8'h30, r); check("R7 all flags", r, 32'hFFF);

    // R4 partial mask
    wr(8'h28, 32'hFFF);
    idle(2);
    check("R4 fully masked", 32'(irq), 0);
    wr(8'h24, 32'h040);
    idle(2);
    check("R4 single unmasked", 32'(irq), 1);
    rd(8'h68, r); check("R6 channel 6", r, 32'(exp_res[6]));
    idle(2);
    check("R4 cleared source", 32'(irq), 0);
    rd(8'h30, r); check("R7 only own flag cleared", r, 32'hFBF);

    // R9 software reset while a request is outstanding
    wr(8'h24, 32'hFFF);
    wr(8'h10, 32'hFFF);
    log_n = 0;
    wr(8'h00, 32'h2);
    idle(5);
    wr(8'h00, 32'h3);
    idle(3);
    check("R9 req dropped", 32'(conv_req), 0);
    check("R9 irq low", 32'(irq), 0);
    rd(8'h18, r); check("R9 enables", r, 0);
    rd(8'h2C, r); check("R9 mask", r, 0);
    rd(8'h30, r); check("R9 flags", r, 0);
    rd(8'h20, r); check("R9 last", r, 0);
    rd(8'h50, r); check("R9 result 0", r, 0);
    begin
      int seen;
      seen = log_n;
      idle(100);
      check("R9 pass abandoned", 32'(log_n), 32'(seen));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule